// File: doc/BRIEF.md
# Symbol Group Boundary Aligner

This block sits on one lane directly behind a transceiver that has already deserialized and 8b10b-decoded the line. Every recovered clock it may receive a 32-bit word of four decoded symbols, four per-symbol control-character flags, and two qualifiers: a ready level for the lane and a per-beat valid strobe. The transceiver's byte lanes can be rotated with respect to the true symbol order, so a four-symbol group may straddle two words.

The aligner keeps the previous accepted word. It joins that word with the current one into an eight-symbol window and tests all four candidate start positions for the link synchronization group. This group is one comma (K.28.5, byte value 0xBC, control flag set) followed by three D.10.5 data symbols (byte value 0xAA, control flag clear). A finite-state machine with states HUNT, CONFIRM and LOCKED commits to a start offset once two consecutive synchronization groups agree on it. From then on it re-emits every accepted window as a word whose byte 0 is the first symbol of a group, together with the matching control flags, for the downstream packet decoder.

State transitions: HUNT goes to CONFIRM on any synchronization group and records its offset. In CONFIRM, a group at the recorded offset moves the machine to LOCKED. A group at another offset stays in CONFIRM and replaces the recorded offset. Accepted words without a group leave the state unchanged. LOCKED holds until reset. Any of the three states returns to HUNT in the cycle after the ready qualifier is low.

Top module: `symbol_aligner`

## Requirements
- R1: While the asynchronous active-low reset is asserted, `al_locked`, `al_valid`, `al_data` and `al_kflag` are all zero.
- R2: A synchronization group is four consecutive stream symbols: 0xBC with its control flag set, then three times 0xAA with the control flag clear. Symbol i of an input word is bits [8i+7:8i] with flag bit i, and symbol 0 is earliest in the stream.
- R3: A group is detected whatever its start position in the stream modulo four (0, 1, 2 or 3), including when it is split across two accepted words.
- R4: `al_locked` rises only after two consecutive detected groups share the same start offset. A detected group at a different offset restarts confirmation with that offset.
- R5: While `al_locked` is low, `al_valid` stays low.
- R6: While locked, each accepted beat that follows another accepted beat produces `al_valid` high one clock later. `al_data` then holds the four stream symbols beginning at the locked offset within the window formed by the previous and current accepted words.
- R7: `al_kflag` carries the control flags of the same four symbols, bit i belonging to output symbol i.
- R8: Once locked, synchronization groups at other offsets do not change the lock or the offset; groups keep appearing at output symbol 0.
- R9: A low `rx_ready` clears the lock and discards the stored word in the next cycle, and a single group afterwards does not re-establish lock.
- R10: Beats with `rx_valid` low are not part of the stream: the window skips them, and `al_valid` is low one clock after each such beat.
- R11: A candidate group with a wrong control flag on any of its four symbols is not detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ready | input | 1 | Lane ready level; low drops lock and stored word |
| rx_valid | input | 1 | Beat qualifier for the input word |
| rx_data | input | 32 | Four decoded symbols, symbol 0 in bits [7:0] |
| rx_kflag | input | 4 | Control-character flag per input symbol |
| al_data | output | 32 | Re-ordered word, byte 0 is a group boundary |
| al_kflag | output | 4 | Control-character flags of the output symbols |
| al_valid | output | 1 | Output word qualifier |
| al_locked | output | 1 | Offset confirmed and held |

## Verification
The properties assume that `rx_ready` is a level that changes only between beats. They also assume that a synchronization group can never overlap itself in one window, which follows from the flag pattern: only the first symbol of a group carries a control flag. The bench builds its stream symbol by symbol and cuts it into words. All start positions are therefore reached by padding with data symbols that can never equal 0xAA or 0xBC. Its ready drops always last whole cycles with valid low, and its idle beats are inserted only between whole words.

// File: rtl/symalign_pkg.sv
package symalign_pkg;
    localparam int unsigned SYM_W     = 8;
    localparam logic [7:0]  COMMA_SYM = 8'hBC;
    localparam logic [7:0]  FILL_SYM  = 8'hAA;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/word_history.sv
module word_history #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [DATA_W-1:0] d_in,
    input  logic [FLAG_W-1:0] k_in,
    output logic [DATA_W-1:0] d_prev,
    output logic [FLAG_W-1:0] k_prev,
    output logic              prev_ok
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_prev  <= '0;
            k_prev  <= '0;
            prev_ok <= 1'b0;
        end else if (flush) begin
            d_prev  <= '0;
            k_prev  <= '0;
            prev_ok <= 1'b0;
        end else if (load) begin
            d_prev  <= d_in;
            k_prev  <= k_in;
            prev_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_detector.sv
module sync_detector
    import symalign_pkg::*;
#(
    parameter int unsigned BYTES = 4
) (
    input  logic [2*BYTES*SYM_W-1:0] win_d,
    input  logic [2*BYTES-1:0]       win_k,
    input  logic                     win_ok,
    output logic [BYTES-1:0]         hit
);
    for (genvar o = 0; o < BYTES; o++) begin : g_cand
        logic match;
        always_comb begin
            match = win_ok;
            for (int j = 0; j < BYTES; j++) begin
                if (j == 0) begin
                    if (win_d[(o+j)*SYM_W +: SYM_W] != COMMA_SYM || !win_k[o+j])
                        match = 1'b0;
                end else begin
                    if (win_d[(o+j)*SYM_W +: SYM_W] != FILL_SYM || win_k[o+j])
                        match = 1'b0;
                end
            end
        end
        assign hit[o] = match;
    end
endmodule

// File: rtl/byte_rotator.sv
module byte_rotator
    import symalign_pkg::*;
#(
    parameter int unsigned BYTES = 4,
    parameter int unsigned OFS_W = 2
) (
    input  logic [2*BYTES*SYM_W-1:0] win_d,
    input  logic [2*BYTES-1:0]       win_k,
    input  logic [OFS_W-1:0]         sel,
    output logic [BYTES*SYM_W-1:0]   rot_d,
    output logic [BYTES-1:0]         rot_k
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_comb begin
            rot_d[b*SYM_W +: SYM_W] = '0;
            rot_k[b] = 1'b0;
            for (int o = 0; o < BYTES; o++) begin
                if (sel == OFS_W'(o)) begin
                    rot_d[b*SYM_W +: SYM_W] = win_d[(o+b)*SYM_W +: SYM_W];
                    rot_k[b] = win_k[o+b];
                end
            end
        end
    end
endmodule

// File: rtl/symbol_aligner.sv
module symbol_aligner
    import symalign_pkg::*;
#(
    parameter int unsigned BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_ready,
    input  logic                   rx_valid,
    input  logic [BYTES*SYM_W-1:0] rx_data,
    input  logic [BYTES-1:0]       rx_kflag,
    output logic [BYTES*SYM_W-1:0] al_data,
    output logic [BYTES-1:0]       al_kflag,
    output logic                   al_valid,
    output logic                   al_locked
);
    localparam int unsigned DATA_W = BYTES * SYM_W;
    localparam int unsigned OFS_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic              accept;
    logic [DATA_W-1:0] prev_d;
    logic [BYTES-1:0]  prev_k;
    logic              prev_ok;
    logic              win_ok;
    logic [BYTES-1:0]  hit;
    logic              hit_any;
    logic [OFS_W-1:0]  hit_ofs;
    logic [DATA_W-1:0] rot_d;
    logic [BYTES-1:0]  rot_k;

    lock_state_t       state, state_nx;
    logic [OFS_W-1:0]  ofs_q, ofs_nx;

    assign accept = rx_ready && rx_valid;
    assign win_ok = accept && prev_ok;

    word_history #(.DATA_W(DATA_W), .FLAG_W(BYTES)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (!rx_ready),
        .load   (accept),
        .d_in   (rx_data),
        .k_in   (rx_kflag),
        .d_prev (prev_d),
        .k_prev (prev_k),
        .prev_ok(prev_ok)
    );

    sync_detector #(.BYTES(BYTES)) u_det (
        .win_d (({rx_data, prev_d})),
        .win_k (({rx_kflag, prev_k})),
        .win_ok(win_ok),
        .hit   (hit)
    );

    byte_rotator #(.BYTES(BYTES), .OFS_W(OFS_W)) u_rot (
        .win_d (({rx_data, prev_d})),
        .win_k (({rx_kflag, prev_k})),
        .sel   (ofs_q),
        .rot_d (rot_d),
        .rot_k (rot_k)
    );

    // lowest matching offset wins
    always_comb begin
        hit_ofs = '0;
        for (int i = BYTES - 1; i >= 0; i--) begin
            if (hit[i]) hit_ofs = OFS_W'(i);
        end
    end
    assign hit_any = |hit;

    // next-state logic
    always_comb begin
        state_nx = state;
        ofs_nx   = ofs_q;
        unique case (state)
            ST_HUNT: begin
                if (hit_any) begin
                    state_nx = ST_CONFIRM;
                    ofs_nx   = hit_ofs;
                end
            end
            ST_CONFIRM: begin
                if (hit_any) begin
                    if (hit_ofs == ofs_q) state_nx = ST_LOCKED;
                    else                  ofs_nx   = hit_ofs;
                end
            end
            ST_LOCKED: begin
                state_nx = ST_LOCKED;
            end
            default: begin
                state_nx = ST_HUNT;
            end
        endcase
        if (!rx_ready) begin
            state_nx = ST_HUNT;
            ofs_nx   = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            ofs_q <= '0;
        end else begin
            state <= state_nx;
            ofs_q <= ofs_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_data  <= '0;
            al_kflag <= '0;
            al_valid <= 1'b0;
        end else if (state == ST_LOCKED && win_ok) begin
            al_data  <= rot_d;
            al_kflag <= rot_k;
            al_valid <= 1'b1;
        end else begin
            al_valid <= 1'b0;
        end
    end

    assign al_locked = (state == ST_LOCKED);
endmodule

// File: rtl/symbol_aligner_chk.sv
module symbol_aligner_chk #(
    parameter int unsigned BYTES = 4,
    parameter int unsigned OFS_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_ready,
    input logic             rx_valid,
    input logic             al_valid,
    input logic             al_locked,
    input logic [BYTES-1:0] hit,
    input logic [OFS_W-1:0] ofs_q
);
    a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !al_locked |=> !al_valid);

    a_r10_valid_from_beat: assert property (@(posedge clk) disable iff (!rst_n)
        al_valid |-> $past(rx_valid && rx_ready));

    a_r9_drop_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |=> !al_locked);

    a_r8_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (al_locked && rx_ready) |=> (al_locked && $stable(ofs_q)));

    a_r4_lock_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_locked) |-> $past(|hit));

    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

bind symbol_aligner symbol_aligner_chk #(.BYTES(BYTES), .OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .al_valid (al_valid),
    .al_locked(al_locked),
    .hit      (hit),
    .ofs_q    (ofs_q)
);

// File: tb/sim_symbol_aligner.sv
`timescale 1ns/1ps
module sim_symbol_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_kflag = '0;
    logic [31:0] al_data;
    logic [3:0]  al_kflag;
    logic        al_valid;
    logic        al_locked;

    always #4 clk = ~clk;

    symbol_aligner u0 (
        .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_kflag(rx_kflag), .al_data(al_data),
        .al_kflag(al_kflag), .al_valid(al_valid), .al_locked(al_locked)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [8:0]  hist[$];
    int          m_state = 0;  // 0 hunt, 1 confirm, 2 locked
    int          m_ofs   = 0;
    logic        e_valid = 1'b0;
    logic [31:0] e_data  = '0;
    logic [3:0]  e_k     = '0;

    function automatic bit is_sync(input int o);
        if (hist[o] != {1'b1, 8'hBC}) return 0;
        for (int j = 1; j < 4; j++)
            if (hist[o+j] != {1'b0, 8'hAA}) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete(); m_state = 0; m_ofs = 0;
            e_valid = 0; e_data = '0; e_k = '0;
        end else if (!rx_ready) begin
            hist.delete(); m_state = 0; m_ofs = 0; e_valid = 0;
        end else if (!rx_valid) begin
            e_valid = 0;
        end else begin
            int found;
            for (int b = 0; b < 4; b++) hist.push_back({rx_kflag[b], rx_data[8*b +: 8]});
            while (hist.size() > 8) void'(hist.pop_front());
            e_valid = 0;
            if (hist.size() == 8) begin
                if (m_state == 2) begin
                    e_valid = 1;
                    for (int b = 0; b < 4; b++) begin
                        e_data[8*b +: 8] = hist[m_ofs+b][7:0];
                        e_k[b] = hist[m_ofs+b][8];
                    end
                end
                found = -1;
                for (int o = 3; o >= 0; o--) if (is_sync(o)) found = o;
                if (found >= 0) begin
                    if (m_state == 0) begin m_state = 1; m_ofs = found; end
                    else if (m_state == 1) begin
                        if (found == m_ofs) m_state = 2;
                        else m_ofs = found;
                    end
                end
            end
        end
    end

    // per-clock comparison
    bit seen_group = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(al_locked == (m_state == 2), "R4 lock state", 32'(al_locked), 32'(m_state == 2));
            chk(al_valid == e_valid, "R5 R10 output valid", 32'(al_valid), 32'(e_valid));
            if (e_valid && al_valid) begin
                chk(al_data == e_data, "R6 aligned data", al_data, e_data);
                chk(al_kflag == e_k, "R7 control flags", 32'(al_kflag), 32'(e_k));
                if (al_data == 32'hAAAAAABC && al_kflag == 4'b0001) seen_group = 1;
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [8:0] tx[$];
    int tx_total = 0;
    int fill_cnt = 0;

    task automatic put(input bit k, input logic [7:0] b);
        tx.push_back({k, b});
        tx_total++;
    endtask

    task automatic put_fill(input int n);
        for (int i = 0; i < n; i++) begin
            fill_cnt++;
            put(1'b0, 8'((fill_cnt * 3) & 8'h7F));
        end
    endtask

    task automatic pad_to(input int r);
        while ((tx_total % 4) != r) put_fill(1);
    endtask

    task automatic put_sync(input int r);
        pad_to(r);
        put(1'b1, 8'hBC);
        for (int i = 0; i < 3; i++) put(1'b0, 8'hAA);
    endtask

    task automatic send_all(input bit gaps);
        pad_to(0);
        put_fill(4);
        while (tx.size() >= 4) begin
            if (gaps) begin
                @(negedge clk); rx_valid = 1'b0;
            end
            @(negedge clk);
            for (int b = 0; b < 4; b++) begin
                logic [8:0] s;
                s = tx.pop_front();
                rx_data[8*b +: 8] = s[7:0];
                rx_kflag[b] = s[8];
            end
            rx_valid = 1'b1;
        end
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic drop_ready();
        @(negedge clk); rx_ready = 1'b0; rx_valid = 1'b0;
        @(negedge clk); rx_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(al_locked == 0, "R1 locked in reset", 32'(al_locked), 0);
        chk(al_valid == 0, "R1 valid in reset", 32'(al_valid), 0);
        chk(al_data == 0, "R1 data in reset", al_data, 0);
        chk(al_kflag == 0, "R1 flags in reset", 32'(al_kflag), 0);
        rst_n = 1'b1;
        rx_ready = 1'b1;

        // every rotation
        for (int r = 0; r < 4; r++) begin
            drop_ready();
            put_fill(6); put_sync(r); put_fill(5); put_sync(r); put_fill(9);
            put_sync(r); put_fill(7);
            send_all(0);
            chk(al_locked == 1, $sformatf("R2 R3 lock at rotation %0d", r), 32'(al_locked), 1);
        end

        // malformed groups
        drop_ready();
        for (int i = 0; i < 2; i++) begin
            pad_to(1); put(1, 8'hBC); put(1, 8'hAA); put(0, 8'hAA); put(0, 8'hAA); put_fill(3);
        end
        send_all(0);
        chk(al_locked == 0, "R11 flag on fill symbol", 32'(al_locked), 0);
        for (int i = 0; i < 2; i++) begin
            pad_to(2); put(0, 8'hBC); put(0, 8'hAA); put(0, 8'hAA); put(0, 8'hAA); put_fill(2);
        end
        send_all(0);
        chk(al_locked == 0, "R11 comma without flag", 32'(al_locked), 0);
        for (int i = 0; i < 2; i++) begin
            pad_to(3); put(1, 8'hBC); put(0, 8'hAA); put(0, 8'hAB); put(0, 8'hAA); put_fill(1);
        end
        send_all(0);
        chk(al_locked == 0, "R2 wrong fill value", 32'(al_locked), 0);

        // confirmation restart
        drop_ready();
        put_sync(1); put_fill(3); put_sync(2); put_fill(6);
        send_all(0);
        chk(al_locked == 0, "R4 differing offsets", 32'(al_locked), 0);
        put_sync(2); put_fill(6);
        send_all(0);
        chk(al_locked == 1, "R4 confirmed at new offset", 32'(al_locked), 1);

        // locked offset held
        put_sync(3); put_fill(5); put_sync(3); put_fill(5);
        send_all(0);
        chk(al_locked == 1, "R8 lock held", 32'(al_locked), 1);
        seen_group = 0;
        put_sync(2); put_fill(6);
        send_all(0);
        chk(seen_group == 1, "R8 group framed at original offset", 32'(seen_group), 1);

        // ready drop
        @(negedge clk); rx_ready = 1'b0;
        @(negedge clk);
        chk(al_locked == 0, "R9 ready drop unlocks", 32'(al_locked), 0);
        rx_ready = 1'b1;
        put_sync(0); put_fill(8);
        send_all(0);
        chk(al_locked == 0, "R9 one group not enough", 32'(al_locked), 0);

        // idle beats between words
        drop_ready();
        put_fill(6); put_sync(1); put_fill(3); put_sync(1); put_fill(10);
        send_all(1);
        chk(al_locked == 1, "R10 lock through idle beats", 32'(al_locked), 1);
        put_fill(5); put_sync(1); put_fill(11);
        send_all(1);
        repeat (2) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule